// File: doc/BRIEF.md
# USART Transmitter with Handshake Gating

This block is the transmit half of a programmable serial port. A host writes parallel characters into a one-entry holding register. The block frames each character and shifts it out on a serial data line. Shifting is paced by a transmit-clock falling-edge strobe from outside the block. In asynchronous mode each character gets a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. Each bit lasts 1, 16 or 64 strobes. In synchronous mode each bit lasts one strobe and no start or stop bits are added. When the holding register is empty, stored sync characters are sent to fill the line.

Two gates control transmission. The first is an active-low clear-to-send input. The second is a transmit-enable command bit. When the transmitter is disabled, the holding register refuses new characters. A character that was already accepted is still sent in full. A break command holds the line low while it is set, and the framing logic keeps running underneath it. The host paces its writes with the ready output. The empty output tells it when no data character remains.

Top module: `usart_tx`

## Requirements
- R1: After reset with transmit-enable low, `txd_o` is 1, `txrdy_o` is 0 and `txempty_o` is 1.
- R2: `txrdy_o` is high exactly when `tx_en_i` is 1, `cts_ni` is 0 and the holding register is empty. A write is taken only in a cycle where `txrdy_o` is high. A write in any other cycle has no effect: nothing is sent and `txempty_o` stays high.
- R3: A character held or in flight when the transmitter is disabled is still sent as a complete frame.
- R4: An asynchronous frame has the following bits, in order, and the line sits at 1 between frames:
  - a start bit of 0;
  - the data bits, LSB first, with the count set to 5 + `char_len_i`;
  - a parity bit when `parity_en_i` is 1, equal to the XOR of the data bits, inverted when `parity_odd_i` is 1;
  - stop bits of 1, two of them when `two_stop_i` is 1 and otherwise one.
- R5: In asynchronous mode each bit lasts 1, 16 or 64 `txc_fall_i` strobes for `baud_sel_i` = 0, 1 or 2/3. In synchronous mode each bit lasts one strobe. `txd_o` changes only on the clock edge that follows a strobe cycle, or through break.
- R6: In synchronous mode a character is sent as its data bits, then parity if enabled, with no start or stop bits. When enabled and the holding register is empty, the block sends sync characters:
  - with `sync_dual_i` = 1, `sync1_i` and `sync2_i` alternate, starting with `sync1_i` after reset;
  - otherwise `sync1_i` repeats.
- R7: `txempty_o` is high exactly when the holding register is empty and no data character is being shifted. It therefore stays high while sync characters fill the line.
- R8: While `break_i` is 1, `txd_o` is 0. The frame in progress keeps advancing and resumes at its current position when break is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txc_fall_i | input | 1 | One-cycle strobe per transmit-clock falling edge |
| sync_mode_i | input | 1 | 1 selects synchronous mode |
| baud_sel_i | input | 2 | Asynchronous bit length: 0 = 1, 1 = 16, 2/3 = 64 strobes |
| char_len_i | input | 2 | Data bits per character minus 5 |
| parity_en_i | input | 1 | Append a parity bit |
| parity_odd_i | input | 1 | 1 selects odd parity |
| two_stop_i | input | 1 | Two stop bits in asynchronous mode |
| sync_dual_i | input | 1 | Alternate two sync characters |
| sync1_i | input | 8 | First sync character |
| sync2_i | input | 8 | Second sync character |
| tx_en_i | input | 1 | Transmit-enable command bit |
| cts_ni | input | 1 | Clear-to-send, active low |
| break_i | input | 1 | Force the line low |
| wr_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Character to transmit |
| txd_o | output | 1 | Serial data out |
| txrdy_o | output | 1 | Holding register can take a character |
| txempty_o | output | 1 | No data character remains |

## Verification
The assertions check four things on every cycle:
- the gating of `txrdy_o` by enable and clear-to-send;
- that an accepted write drops both ready and empty in the next cycle;
- that break forces the line low;
- that the line never moves without a transmit-clock strobe.

Other properties are only visible across a whole scenario. These are frame bit order and parity, the 16 and 64 strobe bit lengths, sync-character alternation, and a character written before a disable still going out. The bench exercises these with dedicated captures and also compares every output against its behavioural model on each clock.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
  localparam int unsigned MIN_CHAR   = 5;
  localparam int unsigned FACTOR_MID = 16;
  localparam int unsigned FACTOR_HI  = 64;
  localparam int unsigned PRE_W      = $clog2(FACTOR_HI);

  typedef enum logic [1:0] {
    BAUD_X1  = 2'd0,
    BAUD_X16 = 2'd1,
    BAUD_X64 = 2'd2
  } baud_sel_e;
endpackage

// File: rtl/usart_tx_baud.sv
module usart_tx_baud
  import usart_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txc_fall_i,
  input  logic       sync_mode_i,
  input  logic [1:0] baud_sel_i,
  output logic       bit_tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;
  logic             wrap;

  always_comb begin
    case (baud_sel_i)
      BAUD_X1:  lim = '0;
      BAUD_X16: lim = PRE_W'(FACTOR_MID - 1);
      default:  lim = PRE_W'(FACTOR_HI - 1);
    endcase
  end

  assign wrap       = (cnt_q == lim);
  assign bit_tick_o = txc_fall_i & (sync_mode_i | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (txc_fall_i && !sync_mode_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/usart_tx_hold.sv
module usart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign ready_o = en_i & ~valid_q;
  assign accept  = wr_i & ready_o;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= wr_data_i;
    end else if (pop_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_tx_framer.sv
module usart_tx_framer
  import usart_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = DATA_W + 4,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               sync_mode_i,
  input  logic [1:0]         char_len_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_W);

  int   nd;
  int   base;
  logic par;

  // Bit 0 of frame_o goes out first; unused upper bits stay at 1 (stop level).
  always_comb begin
    nd      = int'(MIN_CHAR) + int'(char_len_i);
    base    = sync_mode_i ? 0 : 1;
    frame_o = '1;
    if (!sync_mode_i) frame_o[0] = 1'b0;
    par = par_odd_i;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (i < nd) begin
        frame_o[IDX_W'(base + i)] = data_i[i];
        par = par ^ data_i[i];
      end
    end
    if (par_en_i) frame_o[IDX_W'(base + nd)] = par;
    len_o = LEN_W'(base + nd + (par_en_i ? 1 : 0) +
                   (sync_mode_i ? 0 : (two_stop_i ? 2 : 1)));
  end
endmodule

// File: rtl/usart_tx_shift.sv
module usart_tx_shift #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic               load_req_i,
  input  logic               load_data_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               load_o,
  output logic               busy_o,
  output logic               bit_o,
  output logic               cur_data_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               busy_q;
  logic               data_q;
  logic               at_end;

  assign at_end     = ~busy_q | (cnt_q == LEN_W'(1));
  assign load_o     = bit_tick_i & at_end & load_req_i;
  assign busy_o     = busy_q;
  assign bit_o      = sh_q[0];
  assign cur_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      data_q <= 1'b0;
    end else if (bit_tick_i) begin
      if (!at_end) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end else if (load_req_i) begin
        sh_q   <= frame_i;
        cnt_q  <= len_i;
        busy_q <= 1'b1;
        data_q <= load_data_i;
      end else begin
        busy_q <= 1'b0;
        data_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txc_fall_i,
  input  logic              sync_mode_i,
  input  logic [1:0]        baud_sel_i,
  input  logic [1:0]        char_len_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              two_stop_i,
  input  logic              sync_dual_i,
  input  logic [DATA_W-1:0] sync1_i,
  input  logic [DATA_W-1:0] sync2_i,
  input  logic              tx_en_i,
  input  logic              cts_ni,
  input  logic              break_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              txrdy_o,
  output logic              txempty_o
);
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  logic               en;
  logic               bit_tick;
  logic               hold_valid;
  logic [DATA_W-1:0]  hold_data;
  logic               pop;
  logic               sync_fill;
  logic               sptr_q;
  logic [DATA_W-1:0]  char_sel;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic               load;
  logic               busy;
  logic               sh_bit;
  logic               cur_data;

  assign en = tx_en_i & ~cts_ni;

  usart_tx_baud u_baud (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .txc_fall_i  (txc_fall_i),
    .sync_mode_i (sync_mode_i),
    .baud_sel_i  (baud_sel_i),
    .bit_tick_o  (bit_tick)
  );

  usart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .pop_i     (pop),
    .valid_o   (hold_valid),
    .data_o    (hold_data),
    .ready_o   (txrdy_o)
  );

  // Held data always drains, even when disabled; sync fill needs the gate open.
  assign sync_fill = sync_mode_i & en & ~hold_valid;
  assign char_sel  = hold_valid ? hold_data : (sptr_q ? sync2_i : sync1_i);

  usart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .data_i      (char_sel),
    .sync_mode_i (sync_mode_i),
    .char_len_i  (char_len_i),
    .par_en_i    (parity_en_i),
    .par_odd_i   (parity_odd_i),
    .two_stop_i  (two_stop_i),
    .frame_o     (frame),
    .len_o       (frame_len)
  );

  usart_tx_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_tick_i  (bit_tick),
    .load_req_i  (hold_valid | sync_fill),
    .load_data_i (hold_valid),
    .frame_i     (frame),
    .len_i       (frame_len),
    .load_o      (load),
    .busy_o      (busy),
    .bit_o       (sh_bit),
    .cur_data_o  (cur_data)
  );

  assign pop = load & hold_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sptr_q <= 1'b0;
    end else if (load && !hold_valid && sync_dual_i) begin
      sptr_q <= ~sptr_q;
    end
  end

  assign txd_o     = ~break_i & (busy ? sh_bit : 1'b1);
  assign txempty_o = ~hold_valid & ~(busy & cur_data);
endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txc_fall_i,
  input logic tx_en_i,
  input logic cts_ni,
  input logic break_i,
  input logic wr_i,
  input logic txd_o,
  input logic txrdy_o,
  input logic txempty_o
);
  assert_gate_blocks_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i || cts_ni) |-> !txrdy_o);

  assert_accept_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && txrdy_o) |=> !txrdy_o);

  assert_accept_not_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && txrdy_o) |=> !txempty_o);

  assert_break_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |-> !txd_o);

  assert_line_paced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txc_fall_i && !break_i) |=> (break_i || $stable(txd_o)));
endmodule

bind usart_tx usart_tx_chk u_chk (.*);

// File: tb/sim_usart_tx.sv
`timescale 1ns/1ps
module sim_usart_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txc_fall = 1'b0;
  logic       sync_mode = 1'b0;
  logic [1:0] baud_sel = 2'd0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, sync_dual = 1'b0;
  logic [7:0] sync1 = 8'h16, sync2 = 8'h2C;
  logic       tx_en = 1'b0, cts_n = 1'b0, brk = 1'b0, wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, txrdy, txempty;

  int n_chk = 0;
  int n_fail = 0;
  int txp = 1;
  int txc_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usart_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .txc_fall_i(txc_fall), .sync_mode_i(sync_mode),
    .baud_sel_i(baud_sel), .char_len_i(char_len), .parity_en_i(par_en),
    .parity_odd_i(par_odd), .two_stop_i(two_stop), .sync_dual_i(sync_dual),
    .sync1_i(sync1), .sync2_i(sync2), .tx_en_i(tx_en), .cts_ni(cts_n),
    .break_i(brk), .wr_i(wr), .wr_data_i(wr_data),
    .txd_o(txd), .txrdy_o(txrdy), .txempty_o(txempty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_q[$];
  bit m_hv, m_cd, m_sp;
  logic [7:0] m_hd;
  int m_pre;

  function automatic void push_char(input logic [7:0] d);
    bit p;
    int nd;
    nd = 5 + int'(char_len);
    p = par_odd;
    if (!sync_mode) m_q.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      m_q.push_back(d[i]);
      p = p ^ d[i];
    end
    if (par_en) m_q.push_back(p);
    if (!sync_mode) begin
      m_q.push_back(1'b1);
      if (two_stop) m_q.push_back(1'b1);
    end
  endfunction

  always @(posedge clk) begin
    bit en, hv0, tick;
    int fac;
    if (!rst_n) begin
      m_q.delete();
      m_hv = 0; m_cd = 0; m_sp = 0; m_hd = 0; m_pre = 0;
    end else begin
      en  = tx_en && !cts_n;
      hv0 = m_hv;
      fac = (baud_sel == 2'd0) ? 1 : (baud_sel == 2'd1) ? 16 : 64;
      tick = 0;
      if (txc_fall) begin
        if (sync_mode) tick = 1;
        else if (m_pre == fac - 1) begin tick = 1; m_pre = 0; end
        else m_pre++;
      end
      if (tick) begin
        if (m_q.size() > 1) void'(m_q.pop_front());
        else begin
          if (m_q.size() == 1) void'(m_q.pop_front());
          if (m_hv) begin push_char(m_hd); m_hv = 0; m_cd = 1; end
          else if (sync_mode && en) begin
            push_char(m_sp ? sync2 : sync1);
            m_cd = 0;
            if (sync_dual) m_sp = !m_sp;
          end else m_cd = 0;
        end
      end
      if (wr && en && !hv0) begin m_hv = 1; m_hd = wr_data; end
    end
  end

  // Per-cycle comparison, away from both edges
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk("R4 txd vs model", {31'd0, txd}, {31'd0, brk ? 1'b0 : (m_q.size() > 0 ? m_q[0] : 1'b1)});
      chk("R2 txrdy vs model", {31'd0, txrdy}, {31'd0, tx_en && !cts_n && !m_hv});
      chk("R7 txempty vs model", {31'd0, txempty}, {31'd0, !m_hv && !(m_q.size() > 0 && m_cd)});
    end
  end

  // Transmit clock strobe generator
  initial forever begin
    @(negedge clk);
    txc_cnt++;
    if (txc_cnt >= txp) txc_cnt = 0;
    txc_fall = (txc_cnt == 0);
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tx_en = 0; cts_n = 0; brk = 0; wr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!txrdy) @(negedge clk);
    wr = 1; wr_data = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic capture(input int nbits, input int bitcyc, output logic [15:0] v);
    v = '0;
    do begin @(negedge clk); #3; end while (txd !== 1'b0);
    for (int k = 0; k < nbits; k++) begin
      v[k] = txd;
      if (k < nbits - 1) begin
        repeat (bitcyc) @(negedge clk);
        #3;
      end
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [7:0] d, input int nd, input bit pe,
                                            input bit odd, input bit two, output int n);
    logic [15:0] v;
    bit p;
    int k;
    v = '0; k = 0; p = odd;
    v[k] = 1'b0; k++;
    for (int i = 0; i < nd; i++) begin v[k] = d[i]; p = p ^ d[i]; k++; end
    if (pe) begin v[k] = p; k++; end
    v[k] = 1'b1; k++;
    if (two) begin v[k] = 1'b1; k++; end
    n = k;
    return v;
  endfunction

  initial begin
    logic [15:0] got, exp;
    int nb;
    // R1: reset state
    do_reset();
    @(negedge clk); #3;
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 txrdy low", {31'd0, txrdy}, 32'd0);
    chk("R1 txempty high", {31'd0, txempty}, 32'd1);

    // R4: x1, 8 bits, even parity, one stop
    txp = 1; baud_sel = 2'd0; char_len = 2'd3; par_en = 1; par_odd = 0; two_stop = 0;
    do_reset();
    @(negedge clk); tx_en = 1;
    send(8'hA5);
    exp = exp_frame(8'hA5, 8, 1, 0, 0, nb);
    capture(nb, 1, got);
    chk("R4 frame 0xA5 even parity", {16'd0, got}, {16'd0, exp});
    send(8'h3C); send(8'h81);
    repeat (40) @(negedge clk);

    // R5: x16 with strobe every 2 clocks, 5 bits, odd parity, two stops
    txp = 2; baud_sel = 2'd1; char_len = 2'd0; par_en = 1; par_odd = 1; two_stop = 1;
    do_reset();
    @(negedge clk); tx_en = 1;
    send(8'h13);
    exp = exp_frame(8'h13, 5, 1, 1, 1, nb);
    capture(nb, 32, got);
    chk("R5 x16 frame 0x13 odd parity two stops", {16'd0, got}, {16'd0, exp});
    repeat (80) @(negedge clk);

    // R5: x64, 7 bits, no parity
    txp = 1; baud_sel = 2'd2; char_len = 2'd2; par_en = 0; par_odd = 0; two_stop = 0;
    do_reset();
    @(negedge clk); tx_en = 1;
    send(8'h55);
    exp = exp_frame(8'h55, 7, 0, 0, 0, nb);
    capture(nb, 64, got);
    chk("R5 x64 frame 0x55", {16'd0, got}, {16'd0, exp});
    repeat (80) @(negedge clk);

    // R3 and R2: disable right after a write, then write while disabled
    txp = 3; baud_sel = 2'd0; char_len = 2'd1; par_en = 1; par_odd = 0; two_stop = 0;
    do_reset();
    @(negedge clk); tx_en = 1;
    send(8'h2B);
    tx_en = 0;
    exp = exp_frame(8'h2B, 6, 1, 0, 0, nb);
    capture(nb, 3, got);
    chk("R3 frame written before disable sent", {16'd0, got}, {16'd0, exp});
    repeat (10) @(negedge clk);
    wr = 1; wr_data = 8'h00;
    @(negedge clk); wr = 0; #3;
    chk("R2 write while disabled leaves empty", {31'd0, txempty}, 32'd1);
    chk("R2 ready low while disabled", {31'd0, txrdy}, 32'd0);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk); #3;
      chk("R2 ignored write not sent", {31'd0, txd}, 32'd1);
    end
    tx_en = 1; cts_n = 1;
    @(negedge clk);
    wr = 1; wr_data = 8'h00;
    @(negedge clk); wr = 0; #3;
    chk("R2 write with clear-to-send high ignored", {31'd0, txempty}, 32'd1);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk); #3;
      chk("R2 no send with clear-to-send high", {31'd0, txd}, 32'd1);
    end

    // R8: break during a frame of ones
    txp = 1; baud_sel = 2'd0; char_len = 2'd3; par_en = 0; two_stop = 0;
    do_reset();
    @(negedge clk); tx_en = 1;
    send(8'hFF);
    do begin @(negedge clk); #3; end while (txd !== 1'b0);
    @(negedge clk); brk = 1;
    for (int c = 0; c < 3; c++) begin
      #3; chk("R8 break forces low", {31'd0, txd}, 32'd0);
      @(negedge clk);
    end
    brk = 0;
    #3; chk("R8 frame resumes after break", {31'd0, txd}, 32'd1);
    repeat (30) @(negedge clk);

    // R6 and R7: synchronous mode with dual sync characters
    txp = 1; sync_mode = 1; char_len = 2'd3; par_en = 0; sync_dual = 1;
    do_reset();
    @(negedge clk); tx_en = 1;
    got = '0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #3;
      got[k] = txd;
      if (k == 4) chk("R7 empty high during sync fill", {31'd0, txempty}, 32'd1);
    end
    chk("R6 sync1 then sync2", {16'd0, got}, {16'd0, sync2, sync1});
    send(8'h5A);
    #3; chk("R7 empty low with data held", {31'd0, txempty}, 32'd0);
    repeat (40) @(negedge clk); #3;
    chk("R7 empty high after data drained", {31'd0, txempty}, 32'd1);
    sync_mode = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule